// File: doc/BRIEF.md
# Combined Hammer/Press Row Command Sequencer

This block drives the row command stream of a read-disturbance experiment on a single DRAM bank. After a start pulse it repeatedly opens (activate) and closes (precharge) one or two aggressor rows around a chosen victim row. Every interval is an integer count of controller clock cycles, each cycle being one 1.5 ns tick. It supports three patterns. The single-sided pattern hammers one neighbour. The double-sided pattern alternates both neighbours with equal open times. The combined pattern alternates a hammered row held open for the minimum row-active time with a pressed row held open for a longer programmed time.

The sequencer counts every aggressor activation and every tick of the run. When the activation budget is used up it closes the last row, raises a one-cycle done pulse, and keeps both totals until the next start. A bitflip checker elsewhere can then relate a first failure to an activation count. The block also drives the constant fill bytes that an external data path writes into aggressor and victim rows. It does not handle refresh, the data path or the physical interface.

Top module: `rdist_cmd_seq`

## Requirements
- R1: After reset, cmd_act_o, cmd_pre_o, busy_o, done_o and err_o are low, and act_cnt_o and tick_cnt_o are zero.
- R2: Single-sided mode (mode_i = 0) activates only row victim+1 on every activation, with open time max(t_on_i, T_RAS).
- R3: Double-sided mode (mode_i = 1, and reserved code 3 behaves the same) alternates victim−1 and victim+1, lower row first, both with open time max(t_on_i, T_RAS).
- R4: Combined mode (mode_i = 2) alternates victim−1 held open exactly T_RAS cycles and victim+1 held open max(t_on_i, T_RAS) cycles, lower row first.
- R5: An open time (ACT cycle to PRE cycle) is never shorter than T_RAS. A programmed t_on_i below T_RAS is raised to T_RAS.
- R6: Each ACT after the first comes max(t_rp_i, 1) cycles after the preceding PRE. No ACT is issued while a row is open. The first ACT appears in the cycle after the clock edge that samples start_i.
- R7: A run issues exactly budget_i ACT commands, each closed by a PRE, and act_cnt_o then equals budget_i.
- R8: done_o is high for exactly one cycle, the cycle after the final PRE. tick_cnt_o then equals the sum of open times plus (budget−1)·max(t_rp_i,1) plus 1. Both counts hold while inputs change, until the next start.
- R9: Mode, victim, timing and budget are latched at start. Input changes and further start pulses during a run have no effect.
- R10: A start with victim row 0 or NUM_ROWS−1 sets err_o the next cycle and issues no commands and no done pulse. err_o clears on the next start with a valid victim.
- R11: fill_aggr_o is constantly 8'hAA and fill_vict_o is constantly 8'h55.
- R12: A start with budget_i = 0 issues no commands and pulses done_o in the cycle after the start edge, with both counts zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock, one tick per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| mode_i | input | 2 | 0 single, 1 double, 2 combined, 3 as double |
| victim_i | input | ROW_W | Victim row address |
| t_on_i | input | TICK_W | Programmed open time in ticks |
| t_rp_i | input | TICK_W | Precharge wait before the next ACT, in ticks |
| budget_i | input | CNT_W | Number of aggressor activations |
| cmd_act_o | output | 1 | Activate command strobe |
| cmd_pre_o | output | 1 | Precharge command strobe |
| row_o | output | ROW_W | Row address for the current command |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| err_o | output | 1 | Victim at a bank edge, run refused |
| act_cnt_o | output | CNT_W | Total aggressor activations of the run |
| tick_cnt_o | output | ELAP_W | Ticks elapsed from first ACT to final PRE |
| fill_aggr_o | output | 8 | Fill byte for aggressor rows |
| fill_vict_o | output | 8 | Fill byte for victim rows |

## Verification
The bench builds the block with NUM_ROWS = 16, TICK_W = 8 and CNT_W = 8, and keeps T_RAS at 24 ticks. With a 16-row bank, victim row 15 is the last row, so both edge rows can be tested for the error path. The 8-bit timing fields are large enough for pressed open times several times T_RAS while runs stay a few hundred cycles long. Each run logs every ACT and PRE cycle, so every open time, every gap and the order of aggressor rows are compared with values derived from the mode.

// File: rtl/rdist_pkg.sv
package rdist_pkg;
  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_DOUBLE = 2'd1,
    MODE_COMBO  = 2'd2,
    MODE_RSVD   = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_OPEN,
    ST_PRE,
    ST_GAP,
    ST_DONE
  } state_e;

  localparam logic [7:0] FILL_AGGR = 8'hAA;
  localparam logic [7:0] FILL_VICT = 8'h55;
endpackage

// File: rtl/rdist_row_gen.sv
module rdist_row_gen #(
  parameter int ROW_W = 16
) (
  input  logic [ROW_W-1:0]  victim_i,
  input  rdist_pkg::mode_e  mode_i,
  input  logic              sel_i,
  output logic [ROW_W-1:0]  row_o
);
  logic [ROW_W-1:0] side [2];

  // side 0: row below the victim, side 1: row above
  for (genvar s = 0; s < 2; s++) begin : g_side
    if (s == 0) begin : g_lo
      assign side[s] = victim_i - ROW_W'(1);
    end else begin : g_hi
      assign side[s] = victim_i + ROW_W'(1);
    end
  end

  assign row_o = (mode_i == rdist_pkg::MODE_SINGLE) ? side[1] : side[sel_i];
endmodule

// File: rtl/rdist_on_sel.sv
module rdist_on_sel #(
  parameter int TICK_W = 16,
  parameter int T_RAS  = 24
) (
  input  logic [TICK_W-1:0] t_on_i,
  input  rdist_pkg::mode_e  mode_i,
  input  logic              sel_i,
  output logic [TICK_W-1:0] on_o
);
  localparam logic [TICK_W-1:0] RAS = TICK_W'(T_RAS);

  logic [TICK_W-1:0] clamped;

  assign clamped = (t_on_i < RAS) ? RAS : t_on_i;
  // combined mode: lower aggressor is hammered at the minimum
  assign on_o = (mode_i == rdist_pkg::MODE_COMBO && !sel_i) ? RAS : clamped;
endmodule

// File: rtl/rdist_cmd_seq.sv
module rdist_cmd_seq
  import rdist_pkg::*;
#(
  parameter  int NUM_ROWS = 65536,
  parameter  int TICK_W   = 16,
  parameter  int CNT_W    = 24,
  parameter  int ELAP_W   = 40,
  parameter  int T_RAS    = 24,
  localparam int ROW_W    = $clog2(NUM_ROWS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [ROW_W-1:0]  victim_i,
  input  logic [TICK_W-1:0] t_on_i,
  input  logic [TICK_W-1:0] t_rp_i,
  input  logic [CNT_W-1:0]  budget_i,
  output logic              cmd_act_o,
  output logic              cmd_pre_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [CNT_W-1:0]  act_cnt_o,
  output logic [ELAP_W-1:0] tick_cnt_o,
  output logic [7:0]        fill_aggr_o,
  output logic [7:0]        fill_vict_o
);
  localparam logic [ROW_W-1:0]  LAST_ROW = ROW_W'(NUM_ROWS - 1);
  localparam logic [TICK_W-1:0] ONE_T    = TICK_W'(1);

  state_e            state_q;
  mode_e             mode_q;
  logic [ROW_W-1:0]  victim_q, open_row_q, aggr_row;
  logic [TICK_W-1:0] ton_q, trp_q, tmr_q, on_eff, rp_eff;
  logic [CNT_W-1:0]  budget_q, act_cnt_q;
  logic [ELAP_W-1:0] tick_q;
  logic              sel_q, err_q, bad_in;

  rdist_row_gen #(.ROW_W(ROW_W)) u_row_gen (
    .victim_i (victim_q),
    .mode_i   (mode_q),
    .sel_i    (sel_q),
    .row_o    (aggr_row)
  );

  rdist_on_sel #(.TICK_W(TICK_W), .T_RAS(T_RAS)) u_on_sel (
    .t_on_i (ton_q),
    .mode_i (mode_q),
    .sel_i  (sel_q),
    .on_o   (on_eff)
  );

  assign bad_in = (victim_i == '0) || (victim_i >= LAST_ROW);
  assign rp_eff = (trp_q == '0) ? ONE_T : trp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      mode_q     <= MODE_SINGLE;
      victim_q   <= '0;
      open_row_q <= '0;
      ton_q      <= '0;
      trp_q      <= '0;
      tmr_q      <= '0;
      budget_q   <= '0;
      act_cnt_q  <= '0;
      tick_q     <= '0;
      sel_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            mode_q    <= mode_e'(mode_i);
            victim_q  <= victim_i;
            ton_q     <= t_on_i;
            trp_q     <= t_rp_i;
            budget_q  <= budget_i;
            sel_q     <= 1'b0;
            act_cnt_q <= '0;
            tick_q    <= '0;
            err_q     <= bad_in;
            if (bad_in)              state_q <= ST_IDLE;
            else if (budget_i == '0) state_q <= ST_DONE;
            else                     state_q <= ST_ACT;
          end
        end
        ST_ACT: begin
          act_cnt_q  <= act_cnt_q + CNT_W'(1);
          tick_q     <= tick_q + ELAP_W'(1);
          sel_q      <= ~sel_q;
          open_row_q <= aggr_row;
          tmr_q      <= on_eff - ONE_T;
          state_q    <= ST_OPEN;
        end
        ST_OPEN: begin
          tick_q <= tick_q + ELAP_W'(1);
          if (tmr_q == ONE_T) state_q <= ST_PRE;
          else                tmr_q   <= tmr_q - ONE_T;
        end
        ST_PRE: begin
          tick_q <= tick_q + ELAP_W'(1);
          if (act_cnt_q == budget_q) begin
            state_q <= ST_DONE;
          end else if (rp_eff == ONE_T) begin
            state_q <= ST_ACT;
          end else begin
            tmr_q   <= rp_eff - ONE_T;
            state_q <= ST_GAP;
          end
        end
        ST_GAP: begin
          tick_q <= tick_q + ELAP_W'(1);
          if (tmr_q == ONE_T) state_q <= ST_ACT;
          else                tmr_q   <= tmr_q - ONE_T;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_act_o   = (state_q == ST_ACT);
  assign cmd_pre_o   = (state_q == ST_PRE);
  assign row_o       = cmd_act_o ? aggr_row : open_row_q;
  assign busy_o      = (state_q == ST_ACT) || (state_q == ST_OPEN) ||
                       (state_q == ST_PRE) || (state_q == ST_GAP);
  assign done_o      = (state_q == ST_DONE);
  assign err_o       = err_q;
  assign act_cnt_o   = act_cnt_q;
  assign tick_cnt_o  = tick_q;
  assign fill_aggr_o = FILL_AGGR;
  assign fill_vict_o = FILL_VICT;

  // Checker state, driven from the command strobes only
  logic              chk_open_q;
  logic [TICK_W-1:0] chk_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_open_q <= 1'b0;
      chk_len_q  <= '0;
    end else begin
      if (cmd_act_o)      chk_open_q <= 1'b1;
      else if (cmd_pre_o) chk_open_q <= 1'b0;
      if (cmd_act_o)              chk_len_q <= ONE_T;
      else if (chk_len_q != '1)   chk_len_q <= chk_len_q + ONE_T;
    end
  end

  a_r6_no_act_while_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_act_o |-> !chk_open_q);

  a_r7_pre_closes_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pre_o |-> chk_open_q);

  a_r5_min_open_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_pre_o |-> (chk_len_q >= TICK_W'(T_RAS)));

  a_r4_hammer_side_exact: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_pre_o && mode_q == MODE_COMBO && open_row_q == victim_q - ROW_W'(1))
      |-> (chk_len_q == TICK_W'(T_RAS)));

  a_r7_budget_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (act_cnt_o <= budget_q));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !(cmd_act_o || cmd_pre_o || done_o));
endmodule

// File: tb/rdist_cmd_seq_tb.sv
module rdist_cmd_seq_tb;
  localparam int NUM_ROWS = 16;
  localparam int TICK_W   = 8;
  localparam int CNT_W    = 8;
  localparam int ELAP_W   = 32;
  localparam int T_RAS    = 24;
  localparam int ROW_W    = $clog2(NUM_ROWS);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [1:0]        mode = '0;
  logic [ROW_W-1:0]  victim = '0;
  logic [TICK_W-1:0] t_on = '0;
  logic [TICK_W-1:0] t_rp = '0;
  logic [CNT_W-1:0]  budget = '0;
  logic              act, pre, busy, done, err;
  logic [ROW_W-1:0]  row;
  logic [CNT_W-1:0]  act_cnt;
  logic [ELAP_W-1:0] tick_cnt;
  logic [7:0]        fill_a, fill_v;

  rdist_cmd_seq #(
    .NUM_ROWS(NUM_ROWS), .TICK_W(TICK_W), .CNT_W(CNT_W),
    .ELAP_W(ELAP_W), .T_RAS(T_RAS)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .victim_i(victim), .t_on_i(t_on), .t_rp_i(t_rp), .budget_i(budget),
    .cmd_act_o(act), .cmd_pre_o(pre), .row_o(row), .busy_o(busy),
    .done_o(done), .err_o(err), .act_cnt_o(act_cnt), .tick_cnt_o(tick_cnt),
    .fill_aggr_o(fill_a), .fill_vict_o(fill_v)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int act_t [64];
  int act_r [64];
  int pre_t [64];
  int pre_r [64];
  int n_act, n_pre, n_done, done_t, s0;
  int errors = 0;
  int checks = 0;

  always @(negedge clk) begin
    if (act && n_act < 64) begin act_t[n_act] = cyc; act_r[n_act] = int'(row); n_act++; end
    if (pre && n_pre < 64) begin pre_t[n_pre] = cyc; pre_r[n_pre] = int'(row); n_pre++; end
    if (done) begin n_done++; done_t = cyc; end
  end

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic int exp_on(input int m, input int idx, input int ton);
    int c = (ton < T_RAS) ? T_RAS : ton;
    if (m == 2) return (idx % 2 == 0) ? T_RAS : c;
    return c;
  endfunction

  function automatic int exp_row(input int m, input int idx, input int v);
    if (m == 0) return v + 1;
    return (idx % 2 == 0) ? v - 1 : v + 1;
  endfunction

  task automatic clear_mon();
    n_act = 0; n_pre = 0; n_done = 0; done_t = -1;
  endtask

  task automatic launch(input int m, input int v, input int ton, input int trp, input int bud);
    @(negedge clk);
    clear_mon();
    mode = 2'(m); victim = ROW_W'(v); t_on = TICK_W'(ton);
    t_rp = TICK_W'(trp); budget = CNT_W'(bud); start = 1'b1;
    @(posedge clk);
    #1 s0 = cyc;
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (n_done == 0 && n < 5000) begin @(negedge clk); n++; end
    if (n_done == 0) chk("R8 run watchdog", 0, 1);
    @(negedge clk);
  endtask

  task automatic verify(input string req, input int m, input int v, input int ton,
                        input int trp, input int bud);
    int gap = (trp < 1) ? 1 : trp;
    int exp_ticks = 1 + (bud - 1) * gap;
    chk("R7 act count", n_act, bud);
    chk("R7 pre count", n_pre, bud);
    if (n_act > 0) chk("R6 first act cycle", act_t[0], s0);
    for (int i = 0; i < bud && i < n_act && i < n_pre; i++) begin
      exp_ticks += exp_on(m, i, ton);
      chk({req, " row"}, act_r[i], exp_row(m, i, v));
      chk({req, " pre row"}, pre_r[i], act_r[i]);
      chk({req, " R5 open time"}, pre_t[i] - act_t[i], exp_on(m, i, ton));
      if (i + 1 < n_act) chk("R6 gap", act_t[i+1] - pre_t[i], gap);
    end
    chk("R8 done count", n_done, 1);
    if (n_pre > 0) chk("R8 done cycle", done_t, pre_t[n_pre-1] + 1);
    chk("R7 act_cnt_o", int'(act_cnt), bud);
    chk("R8 tick_cnt_o", int'(tick_cnt), exp_ticks);
  endtask

  task automatic t_reset();
    chk("R1 act", int'(act), 0);
    chk("R1 pre", int'(pre), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 act_cnt", int'(act_cnt), 0);
    chk("R1 tick_cnt", int'(tick_cnt), 0);
  endtask

  task automatic t_fill();
    chk("R11 aggr fill", int'(fill_a), 8'hAA);
    chk("R11 victim fill", int'(fill_v), 8'h55);
  endtask

  task automatic t_single();
    launch(0, 6, 40, 10, 5); wait_done(); verify("R2 single", 0, 6, 40, 10, 5);
  endtask

  task automatic t_double();
    launch(1, 3, 30, 0, 6); wait_done(); verify("R3 double", 1, 3, 30, 0, 6);
    launch(3, 10, 50, 2, 4); wait_done(); verify("R3 reserved", 3, 10, 50, 2, 4);
  endtask

  task automatic t_combo();
    launch(2, 7, 90, 10, 6); wait_done(); verify("R4 combined", 2, 7, 90, 10, 6);
  endtask

  task automatic t_clamp();
    launch(1, 4, 5, 3, 3); wait_done(); verify("R5 double clamp", 1, 4, 5, 3, 3);
    launch(2, 4, 0, 1, 4); wait_done(); verify("R5 combined clamp", 2, 4, 0, 1, 4);
  endtask

  task automatic t_hold();
    launch(2, 8, 70, 4, 3); wait_done();
    repeat (2) @(negedge clk);
    victim = 4'd2; mode = 2'd0; t_on = 8'd30; budget = 8'd9; t_rp = 8'd7;
    repeat (6) @(negedge clk);
    chk("R8 hold act_cnt", int'(act_cnt), 3);
    chk("R8 hold tick_cnt", int'(tick_cnt), 24 + 70 + 24 + 2 * 4 + 1);
    chk("R8 hold no act", n_act, 3);
  endtask

  task automatic t_ignore();
    launch(2, 5, 60, 3, 4);
    repeat (20) @(negedge clk);
    mode = 2'd0; victim = 4'd9; t_on = 8'd30; t_rp = 8'd0; budget = 8'd9;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    verify("R9 latched", 2, 5, 60, 3, 4);
  endtask

  task automatic t_err();
    launch(1, 0, 30, 2, 4);
    repeat (40) @(negedge clk);
    chk("R10 err low edge", int'(err), 1);
    chk("R10 no act low edge", n_act, 0);
    chk("R10 no done low edge", n_done, 0);
    chk("R10 idle", int'(busy), 0);
    launch(2, NUM_ROWS - 1, 30, 2, 4);
    repeat (40) @(negedge clk);
    chk("R10 err high edge", int'(err), 1);
    chk("R10 no act high edge", n_act, 0);
    chk("R10 no done high edge", n_done, 0);
    launch(0, 1, 24, 2, 2);
    #4 chk("R10 err cleared", int'(err), 0);
    wait_done();
    verify("R10 recovery", 0, 1, 24, 2, 2);
  endtask

  task automatic t_zero();
    launch(1, 5, 30, 2, 0);
    #4 chk("R12 done at once", int'(done), 1);
    repeat (20) @(negedge clk);
    chk("R12 done count", n_done, 1);
    chk("R12 done cycle", done_t, s0);
    chk("R12 no act", n_act, 0);
    chk("R12 act_cnt", int'(act_cnt), 0);
    chk("R12 tick_cnt", int'(tick_cnt), 0);
  endtask

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_fill();
    t_single();
    t_double();
    t_combo();
    t_clamp();
    t_hold();
    t_ignore();
    t_err();
    t_zero();
    t_fill();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R8 global watchdog: actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule